// File: doc/BRIEF.md
# Receive FIFO Fill Controller

This block decides which received bytes go into a 64-byte receive FIFO and which are thrown away. Incoming bytes arrive on a byte-valid stream. They are stored only while a fill-active state is set.

In automatic mode the fill-active state arms on a sync-detected pulse. Software can clear it to wait for the next sync word. In manual mode software starts and stops filling directly. A byte that arrives while the FIFO is full raises a sticky overrun flag and blocks further writes. Clearing that flag flushes the FIFO and starts a fresh receive. Software reads the stored bytes through a pop strobe with a one-cycle registered read port.

A single 3-bit control word is written with a write strobe and read back as a status word:
- bit 0: fill method (0 = automatic, 1 = manual).
- bit 1: fill active.
- bit 2: overrun.

Top module: `rxfill_top`

## Requirements
- R1: After reset the status word `regRdata` reads 3'b000, `fifoNotEmpty` is 0 and `fifoFull` is 0.
- R2: In automatic mode (bit 0 = 0) with no overrun pending, a `syncPulse` sets fill active (bit 1) one cycle later. A byte that is valid in the same cycle as the pulse is not stored. Bytes that are valid while fill is active are stored.
- R3: In automatic mode, a write with bit 1 = 1 and bit 2 = 0 clears fill active, and later bytes are discarded until the next sync pulse. If an overrun is pending, this write leaves fill active unchanged. A write with bit 1 = 0 has no effect on fill active in this mode.
- R4: In manual mode (bit 0 = 1), a write with bit 2 = 0 sets fill active to the written bit 1. `syncPulse` has no effect in manual mode.
- R5: Bytes that arrive while fill active is 0 are dropped, and no flag changes.
- R6: Stored bytes are read out in arrival order. A `popReq` while `fifoNotEmpty` is 1 places the oldest byte on `popData` in the following cycle. A `popReq` on an empty FIFO leaves `popData` and the FIFO unchanged.
- R7: `fifoFull` is 1 exactly when 64 bytes are held. `fifoNotEmpty` is 1 when at least one byte is held.
- R8: A valid byte that arrives while fill is active and the FIFO is full sets the overrun flag (bit 2), and that byte is dropped. While the flag is set, no byte is stored, even after pops free space, and the flag stays set.
- R9: A write with bit 2 = 1 does three things:
  - it clears the overrun flag;
  - it empties the FIFO;
  - it sets fill active to 0 in automatic mode, or to the written bit 1 in manual mode.
- R10: The status word `regRdata` is {overrun, fill active, fill method} in bits 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte |
| syncPulse | input | 1 | Sync word detected, one cycle |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 3 | Control word write data |
| regRdata | output | 3 | Status word {overrun, fill, method} |
| popReq | input | 1 | Read one byte from the FIFO |
| popData | output | 8 | Byte read, valid the cycle after the pop |
| fifoFull | output | 1 | FIFO holds 64 bytes |
| fifoNotEmpty | output | 1 | FIFO holds at least one byte |

## Verification
The assertions check the following on every cycle:
- no push happens into a full FIFO and no pop happens from an empty one;
- a pending overrun blocks every push and stays set until it is cleared;
- a flush leaves the FIFO empty;
- a sync pulse arms automatic filling;
- manual writes are followed by fill active.

Only the bench scenarios can show that bytes come out in order and with the right values. The same holds for the byte dropped on the sync cycle and for the block ignoring sync pulses and zero writes in the modes where they must have no effect. The bench also shows that the write which would overflow the FIFO is lost and that the flush discards content.

// File: rtl/rxfill_pkg.sv
package rxfill_pkg;
  localparam int CTRL_W = 3;
  localparam int BIT_METHOD = 0;
  localparam int BIT_FILL = 1;
  localparam int BIT_OVR = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/rxfill_ctrl.sv
module rxfill_ctrl
  import rxfill_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              syncPulse,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  input  logic              popReq,
  input  logic              fifoFull,
  input  logic              fifoNotEmpty,
  output fifoStrobe_t       strobes,
  output logic [CTRL_W-1:0] regRdata
);
  logic methodManual, fillActive, overrun;
  logic wrMethod, wrFill, wrOvrClr, overrunEvent;

  assign wrMethod = regWdata[BIT_METHOD];
  assign wrFill   = regWdata[BIT_FILL];
  assign wrOvrClr = regWe && regWdata[BIT_OVR];

  assign overrunEvent  = byteValid && fillActive && !overrun && fifoFull;
  assign strobes.push  = byteValid && fillActive && !overrun && !fifoFull && !wrOvrClr;
  assign strobes.pop   = popReq && fifoNotEmpty && !wrOvrClr;
  assign strobes.flush = wrOvrClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methodManual <= 1'b0;
      fillActive   <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      if (regWe) methodManual <= wrMethod;
      if (wrOvrClr) begin
        overrun    <= 1'b0;
        fillActive <= wrMethod && wrFill;
      end else begin
        if (overrunEvent) overrun <= 1'b1;
        if (regWe && wrMethod)
          fillActive <= wrFill;
        else if (regWe && !wrMethod && wrFill && !overrun)
          fillActive <= 1'b0;
        else if (!methodManual && syncPulse && !overrun)
          fillActive <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    regRdata[BIT_METHOD] = methodManual;
    regRdata[BIT_FILL]   = fillActive;
    regRdata[BIT_OVR]    = overrun;
  end

  // R8: a pending overrun blocks every write into the FIFO
  p_ovr_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !strobes.push);

  // R8: the overrun flag stays set until it is cleared by a write
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !wrOvrClr) |=> overrun);

  // R2: a sync pulse in automatic mode arms filling
  p_sync_arms_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!methodManual && syncPulse && !overrun && !regWe) |=> fillActive);

  // R4: in manual mode, fill active follows the written bit
  p_manual_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && wrMethod && !wrOvrClr) |=> (fillActive == $past(wrFill)));
endmodule

// File: rtl/rxfill_fifo.sv
module rxfill_fifo
  import rxfill_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              notEmpty
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W:0]   wrPtr, rdPtr;

  assign full     = (wrPtr[ADDR_W] != rdPtr[ADDR_W]) &&
                    (wrPtr[ADDR_W-1:0] == rdPtr[ADDR_W-1:0]);
  assign notEmpty = (wrPtr != rdPtr);

  always_ff @(posedge clk) begin
    if (strobes.push && !strobes.flush) mem[wrPtr[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop) begin
        rdData <= mem[rdPtr[ADDR_W-1:0]];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

  // R7: never write into a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> !full);

  // R6: never pop from an empty FIFO
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> notEmpty);

  // R9: a flush leaves the FIFO empty
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> !notEmpty);
endmodule

// File: rtl/rxfill_top.sv
module rxfill_top
  import rxfill_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              syncPulse,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              fifoFull,
  output logic              fifoNotEmpty
);
  fifoStrobe_t strobes;

  rxfill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .syncPulse(syncPulse),
    .regWe(regWe), .regWdata(regWdata), .popReq(popReq),
    .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty),
    .strobes(strobes), .regRdata(regRdata)
  );

  rxfill_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(byteData),
    .rdData(popData), .full(fifoFull), .notEmpty(fifoNotEmpty)
  );
endmodule

// File: tb/tb_rxfill_top.sv
module tb_rxfill_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       syncPulse = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regWdata = '0;
  logic [2:0] regRdata;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic       fifoFull, fifoNotEmpty;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  rxfill_top dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .syncPulse(syncPulse), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .popReq(popReq), .popData(popData),
    .fifoFull(fifoFull), .fifoNotEmpty(fifoNotEmpty)
  );

  // Vector layout:
  //   [27] we, [26:24] wd, [23] sync, [22] bv, [21:14] byte, [13] pop,
  //   [12:10] expected status, [9] expected notEmpty,
  //   [8:1] expected popData, [0] compare popData
  localparam int NV = 17;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0,3'b000,1'b0,1'b1,8'h11,1'b0, 3'b000,1'b0,8'h00,1'b0}, // R5 idle byte dropped
    {1'b0,3'b000,1'b1,1'b1,8'h22,1'b0, 3'b010,1'b0,8'h00,1'b0}, // R2 sync arms, byte lost
    {1'b0,3'b000,1'b0,1'b1,8'h33,1'b0, 3'b010,1'b1,8'h00,1'b0}, // R2 stored
    {1'b0,3'b000,1'b0,1'b1,8'h44,1'b0, 3'b010,1'b1,8'h00,1'b0}, // R2 stored
    {1'b1,3'b000,1'b0,1'b0,8'h00,1'b0, 3'b010,1'b1,8'h00,1'b0}, // R3 zero write ignored
    {1'b1,3'b010,1'b0,1'b0,8'h00,1'b0, 3'b000,1'b1,8'h00,1'b0}, // R3 clear fill
    {1'b0,3'b000,1'b0,1'b1,8'h55,1'b0, 3'b000,1'b1,8'h00,1'b0}, // R3 byte discarded
    {1'b0,3'b000,1'b0,1'b0,8'h00,1'b1, 3'b000,1'b1,8'h33,1'b1}, // R6 first out
    {1'b0,3'b000,1'b0,1'b0,8'h00,1'b1, 3'b000,1'b0,8'h44,1'b1}, // R6 second out
    {1'b0,3'b000,1'b0,1'b0,8'h00,1'b1, 3'b000,1'b0,8'h44,1'b1}, // R6 pop on empty
    {1'b1,3'b001,1'b0,1'b0,8'h00,1'b0, 3'b001,1'b0,8'h00,1'b0}, // R4 manual, stopped
    {1'b0,3'b000,1'b1,1'b0,8'h00,1'b0, 3'b001,1'b0,8'h00,1'b0}, // R4 sync ignored
    {1'b1,3'b011,1'b0,1'b0,8'h00,1'b0, 3'b011,1'b0,8'h00,1'b0}, // R4 start
    {1'b0,3'b000,1'b0,1'b1,8'h66,1'b0, 3'b011,1'b1,8'h00,1'b0}, // R4 stored
    {1'b1,3'b001,1'b0,1'b0,8'h00,1'b0, 3'b001,1'b1,8'h00,1'b0}, // R4 stop
    {1'b0,3'b000,1'b0,1'b1,8'h77,1'b0, 3'b001,1'b1,8'h00,1'b0}, // R5 dropped
    {1'b0,3'b000,1'b0,1'b0,8'h00,1'b1, 3'b001,1'b0,8'h66,1'b1}  // R6 only 66 kept
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs are driven at a falling edge, take effect at the next rising
  // edge, and the outputs are sampled at the following falling edge.
  task automatic step(input logic we, input logic [2:0] wd, input logic sy,
                      input logic bv, input logic [7:0] bd, input logic pp);
    regWe = we; regWdata = wd; syncPulse = sy;
    byteValid = bv; byteData = bd; popReq = pp;
    @(posedge clk);
    @(negedge clk);
    regWe = 0; syncPulse = 0; byteValid = 0; popReq = 0;
  endtask

  task automatic fill64();
    for (int i = 0; i < 64; i++) step(0, 3'b000, 0, 1, 8'(i), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", regRdata, 0);
    check("R1 notEmpty", fifoNotEmpty, 0);
    check("R1 full", fifoFull, 0);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      e = VEC[v];
      step(e[27], e[26:24], e[23], e[22], e[21:14], e[13]);
      check($sformatf("R10 vec%0d status", v), regRdata, e[12:10]);
      check($sformatf("R7 vec%0d notEmpty", v), fifoNotEmpty, e[9]);
      if (e[0]) check($sformatf("R6 vec%0d popData", v), popData, e[8:1]);
    end

    // Automatic mode: fill to full, then overrun
    step(1, 3'b100, 0, 0, 0, 0);
    check("R9 clear to auto", regRdata, 3'b000);
    step(0, 3'b000, 1, 0, 0, 0);
    fill64();
    check("R7 full at 64", fifoFull, 1);
    check("R8 no overrun yet", regRdata, 3'b010);
    step(0, 3'b000, 0, 1, 8'hEE, 0);
    check("R8 overrun set", regRdata, 3'b110);
    step(0, 3'b000, 0, 0, 0, 1);
    check("R6 oldest byte", popData, 0);
    check("R7 not full after pop", fifoFull, 0);
    step(0, 3'b000, 0, 1, 8'hAB, 0);
    check("R8 write blocked", fifoFull, 0);
    check("R8 flag sticky", regRdata, 3'b110);
    step(1, 3'b010, 0, 0, 0, 0);
    check("R3 clear ignored during overrun", regRdata, 3'b110);
    step(0, 3'b000, 0, 0, 0, 1);
    check("R6 second byte", popData, 1);
    step(1, 3'b100, 0, 0, 0, 0);
    check("R9 status after clear", regRdata, 3'b000);
    check("R9 flushed", fifoNotEmpty, 0);
    step(0, 3'b000, 0, 1, 8'h5A, 0);
    check("R9 waits for sync", fifoNotEmpty, 0);
    step(0, 3'b000, 1, 0, 0, 0);
    step(0, 3'b000, 0, 1, 8'hC3, 0);
    check("R2 refill after sync", fifoNotEmpty, 1);
    step(0, 3'b000, 0, 0, 0, 1);
    check("R6 refill data", popData, 8'hC3);

    // Manual mode: overrun, then clear with fill requested
    step(1, 3'b011, 0, 0, 0, 0);
    fill64();
    step(0, 3'b000, 0, 1, 8'hFF, 0);
    check("R8 manual overrun", regRdata, 3'b111);
    step(1, 3'b111, 0, 0, 0, 0);
    check("R9 manual clear keeps fill", regRdata, 3'b011);
    check("R9 manual flushed", fifoNotEmpty, 0);
    step(0, 3'b000, 0, 1, 8'h42, 0);
    step(0, 3'b000, 0, 0, 0, 1);
    check("R9 manual restart data", popData, 8'h42);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule